// File: doc/BRIEF.md
# Scatter-Gather Descriptor Splitter

This block turns a list of memory segments, each an address and a byte length, into a table of 16-byte DMA descriptors for a bus-master engine that cannot move a buffer across a 64 KiB address boundary. Every segment is cut into chunks that each stay inside one 64 KiB aligned window. Each chunk becomes one descriptor, sent as four 32-bit words on a valid/ready stream.

A list ends in one of two ways. The first is a segment offered with `seg_last` set, after which that segment is processed. The second is a segment of length zero, which carries no data. The block keeps the newest descriptor back until it knows whether another one follows. It can then mark the true final descriptor with an end-of-list flag before sending it.

When the list ends, `list_done` pulses for one cycle together with the descriptor count. If the list would need more descriptors than the table holds, the block drops the held descriptor, raises `list_fail` and reports a count of zero. A count of zero tells the host to move the data by programmed I/O instead.

Top module: `sg_desc_splitter`

## Requirements
- R1: Each chunk length is 0x10000 minus bits 15:0 of the current address, limited to the bytes left in the segment. A chunk is never zero and never reaches past the next 64 KiB boundary.
- R2: After each chunk, the address advances by the chunk length and the remaining length drops by the same amount. Chunks of one segment are emitted in increasing address order until nothing remains, and segments are handled in the order received.
- R3: A descriptor is four consecutive words, in this order: zero, chunk address, zero, length value. The length value holds the chunk length in bits 16:0, so a full 64 KiB chunk sets bit 16.
- R4: Every descriptor word is sent big-endian. Bits 31:24 of the value appear on `desc_word[7:0]`, bits 23:16 on `[15:8]`, bits 15:8 on `[23:16]` and bits 7:0 on `[31:24]`.
- R5: Bit 31 of the length value is set in the last descriptor of a successful list and clear in every other descriptor. After byte swapping, this bit appears on `desc_word[7]` of the fourth word.
- R6: A list may hold at most PAGE_BYTES/64 descriptors (64 by default). A list that needs one more ends with `list_fail` = 1 and `list_count` = 0. None of its descriptors carries the end-of-list bit, and the rest of its segments are accepted and dropped.
- R7: A list whose first segment has length zero produces no descriptor words and ends with count 0 and fail 0.
- R8: A zero-length segment ends the list without adding a descriptor. A nonzero segment with `seg_last` set ends the list after its chunks.
- R9: `list_done` is high for exactly one cycle per list, after the list's last descriptor word has been accepted. `list_count` then equals the number of descriptors sent.
- R10: While `desc_valid` is high and `desc_ready` is low, `desc_word` and `desc_valid` hold their values.
- R11: After reset, `desc_valid` and `list_done` are low and `seg_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when both valid and ready are high |
| seg_addr | input | 32 | Segment start byte address |
| seg_len | input | LEN_W (20) | Segment length in bytes; zero ends the list |
| seg_last | input | 1 | This nonzero segment is the last of the list |
| desc_valid | output | 1 | Descriptor word available |
| desc_ready | input | 1 | Consumer takes the word |
| desc_word | output | 32 | Descriptor word, big-endian |
| list_done | output | 1 | One-cycle end-of-list pulse |
| list_count | output | CNT_W (7) | Descriptors in the list; 0 on failure or empty list |
| list_fail | output | 1 | Table capacity exceeded |

## Verification
A wrong remaining-length or address register shows up at once as a wrong address or length word in the next descriptor. It also shifts every later chunk boundary, so one bad split changes all words after it in the same list. A lost or stuck held-back descriptor shows up at the end of the list: the end-of-list bit sits on the wrong descriptor, or the count and the number of descriptors sent disagree. A wrong entry counter shows up as a missing or early fail indication on the 64- and 65-entry lists.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

  localparam int SGC_CHUNK_W = 17;

  typedef enum logic [2:0] {
    ST_ACCEPT,
    ST_SPLIT,
    ST_FLUSH,
    ST_DRAIN,
    ST_FINISH
  } sgc_state_e;

  typedef struct packed {
    logic [31:0]            addr;
    logic [SGC_CHUNK_W-1:0] len;
    logic                   eol;
  } sgc_desc_t;

  function automatic logic [31:0] sgc_bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/sgc_chunk_calc.sv
module sgc_chunk_calc
  import sgc_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic [31:0]            cur_addr,
  input  logic [LEN_W-1:0]       cur_rem,
  output logic [SGC_CHUNK_W-1:0] chunk,
  output logic [31:0]            nxt_addr,
  output logic [LEN_W-1:0]       nxt_rem,
  output logic                   seg_end
);

  localparam int CMP_W = (LEN_W > SGC_CHUNK_W) ? LEN_W : SGC_CHUNK_W;

  logic [SGC_CHUNK_W-1:0] room;
  logic [CMP_W-1:0]       room_w;
  logic [CMP_W-1:0]       rem_w;

  always_comb begin
    room   = 17'h10000 - {1'b0, cur_addr[15:0]};
    room_w = CMP_W'(room);
    rem_w  = CMP_W'(cur_rem);
    if (rem_w < room_w) chunk = SGC_CHUNK_W'(rem_w);
    else                chunk = room;
    nxt_addr = cur_addr + 32'(chunk);
    nxt_rem  = cur_rem - LEN_W'(chunk);
    seg_end  = (nxt_rem == '0);
  end

endmodule

// File: rtl/sgc_word_emitter.sv
module sgc_word_emitter
  import sgc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  sgc_desc_t   desc_in,
  output logic        busy,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word
);

  logic      busy_q, busy_d;
  logic [1:0] idx_q, idx_d;
  sgc_desc_t desc_q;
  logic      load_en;

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    load_en = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        idx_d   = 2'd0;
        load_en = 1'b1;
      end
    end else if (out_ready) begin
      idx_d = idx_q + 2'd1;
      if (idx_q == 2'd3) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= 2'd0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       desc_q <= '0;
    else if (load_en) desc_q <= desc_in;
  end

  always_comb begin
    unique case (idx_q)
      2'd1:    out_word = sgc_bswap(desc_q.addr);
      2'd3:    out_word = sgc_bswap({desc_q.eol, 14'd0, desc_q.len});
      default: out_word = 32'd0;
    endcase
  end

  assign busy      = busy_q;
  assign out_valid = busy_q;

  // R10: a stalled word stays put
  p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  p_start_only_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

endmodule

// File: rtl/sg_desc_splitter.sv
module sg_desc_splitter
  import sgc_pkg::*;
#(
  parameter int LEN_W      = 20,
  parameter int PAGE_BYTES = 4096,
  localparam int MAX_ENT   = PAGE_BYTES / 64,
  localparam int CNT_W     = $clog2(MAX_ENT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_last,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic [31:0]      desc_word,
  output logic             list_done,
  output logic [CNT_W-1:0] list_count,
  output logic             list_fail
);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  sgc_state_e             state_q, state_d;
  logic [31:0]            cur_addr_q, cur_addr_d;
  logic [LEN_W-1:0]       cur_rem_q, cur_rem_d;
  logic                   cur_last_q, cur_last_d;
  sgc_desc_t              pend_q, pend_d;
  logic                   pend_vld_q, pend_vld_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   fail_q, fail_d;

  logic [SGC_CHUNK_W-1:0] chunk;
  logic [31:0]            nxt_addr;
  logic [LEN_W-1:0]       nxt_rem;
  logic                   seg_end;
  logic                   em_start, em_busy, step, at_cap;
  sgc_desc_t              em_desc;

  sgc_chunk_calc #(.LEN_W(LEN_W)) u_calc (
    .cur_addr (cur_addr_q),
    .cur_rem  (cur_rem_q),
    .chunk    (chunk),
    .nxt_addr (nxt_addr),
    .nxt_rem  (nxt_rem),
    .seg_end  (seg_end)
  );

  sgc_word_emitter u_emit (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (em_start),
    .desc_in   (em_desc),
    .busy      (em_busy),
    .out_valid (desc_valid),
    .out_ready (desc_ready),
    .out_word  (desc_word)
  );

  assign at_cap    = (cnt_q == CNT_W'(MAX_ENT));
  assign seg_ready = (state_q == ST_ACCEPT) || (state_q == ST_DRAIN);
  assign list_done = (state_q == ST_FINISH) && !em_busy;
  assign list_count = fail_q ? '0 : cnt_q;
  assign list_fail = fail_q;

  always_comb begin
    state_d    = state_q;
    cur_addr_d = cur_addr_q;
    cur_rem_d  = cur_rem_q;
    cur_last_d = cur_last_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    cnt_d      = cnt_q;
    fail_d     = fail_q;
    em_start   = 1'b0;
    em_desc    = pend_q;
    step       = 1'b0;
    unique case (state_q)
      ST_ACCEPT: begin
        if (seg_valid) begin
          if (seg_len == '0) begin
            state_d = pend_vld_q ? ST_FLUSH : ST_FINISH;
          end else begin
            cur_addr_d = seg_addr;
            cur_rem_d  = seg_len;
            cur_last_d = seg_last;
            state_d    = ST_SPLIT;
          end
        end
      end
      ST_SPLIT: begin
        if (at_cap) begin
          fail_d     = 1'b1;
          pend_vld_d = 1'b0;
          state_d    = cur_last_q ? ST_FINISH : ST_DRAIN;
        end else if (!(pend_vld_q && em_busy)) begin
          step        = 1'b1;
          em_start    = pend_vld_q;
          em_desc.eol = 1'b0;
          pend_d.addr = cur_addr_q;
          pend_d.len  = chunk;
          pend_d.eol  = 1'b0;
          pend_vld_d  = 1'b1;
          cnt_d       = cnt_q + CNT_W'(1);
          cur_addr_d  = nxt_addr;
          cur_rem_d   = nxt_rem;
          if (seg_end) state_d = cur_last_q ? ST_FLUSH : ST_ACCEPT;
        end
      end
      ST_FLUSH: begin
        if (!em_busy) begin
          em_start    = 1'b1;
          em_desc.eol = 1'b1;
          pend_vld_d  = 1'b0;
          state_d     = ST_FINISH;
        end
      end
      ST_DRAIN: begin
        if (seg_valid && ((seg_len == '0) || seg_last)) state_d = ST_FINISH;
      end
      ST_FINISH: begin
        if (!em_busy) begin
          cnt_d      = '0;
          fail_d     = 1'b0;
          pend_vld_d = 1'b0;
          state_d    = ST_ACCEPT;
        end
      end
      default: state_d = ST_ACCEPT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q    <= ST_ACCEPT;
      cur_addr_q <= '0;
      cur_rem_q  <= '0;
      cur_last_q <= 1'b0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      cnt_q      <= '0;
      fail_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      cur_addr_q <= cur_addr_d;
      cur_rem_q  <= cur_rem_d;
      cur_last_q <= cur_last_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
      cnt_q      <= cnt_d;
      fail_q     <= fail_d;
    end
  end

  // R1: each chunk taken is nonzero and stays inside its 64 KiB window
  p_chunk_window_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    step |-> ((chunk != '0) &&
              ((18'(cur_addr_q[15:0]) + 18'(chunk)) <= 18'h10000)));

  // R6: the entry counter never passes the table size
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    cnt_q <= CNT_W'(MAX_ENT));

  // R6: a failed list reports a zero count
  p_fail_zero_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (list_done && list_fail) |-> (list_count == '0));

  // R9: the done pulse lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    list_done |=> !list_done);

  // R9: done only when no word is outstanding
  p_done_drained_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    list_done |-> !desc_valid);

endmodule

// File: tb/sg_desc_splitter_bench.sv
`timescale 1ns/1ps
module sg_desc_splitter_bench;

  localparam int LEN_W   = 20;
  localparam int MAX_ENT = 64;
  localparam int CNT_W   = 7;

  logic             clk;
  logic             rst_n;
  logic             seg_valid;
  logic             seg_ready;
  logic [31:0]      seg_addr;
  logic [LEN_W-1:0] seg_len;
  logic             seg_last;
  logic             desc_valid;
  logic             desc_ready;
  logic [31:0]      desc_word;
  logic             list_done;
  logic [CNT_W-1:0] list_count;
  logic             list_fail;

  sg_desc_splitter #(.LEN_W(LEN_W), .PAGE_BYTES(4096)) u_sg_desc_splitter (
    .clk(clk), .rst_n(rst_n),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_word(desc_word),
    .list_done(list_done), .list_count(list_count), .list_fail(list_fail)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk;
  int n_bad;

  logic [31:0]      s_addr [0:127];
  logic [LEN_W-1:0] s_len  [0:127];
  logic             s_last [0:127];
  int               n_seg;

  logic [31:0] e_addr [0:255];
  logic [16:0] e_len  [0:255];
  int          e_cnt;
  bit          e_fail;

  logic [31:0] got_w [0:1023];
  int          got_n;
  bit          done_seen;
  logic [CNT_W-1:0] got_cnt;
  bit          got_fail;
  bit          bp_en;
  logic [7:0]  lfsr;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] swap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // ready driver, changes just after each rising edge
  initial begin
    desc_ready = 1'b1;
    lfsr = 8'h5a;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      desc_ready = bp_en ? lfsr[0] : 1'b1;
    end
  end

  // collector, samples at the falling edge
  always @(negedge clk) begin
    if (rst_n && desc_valid && desc_ready && got_n < 1024) begin
      got_w[got_n] = desc_word;
      got_n++;
    end
    if (rst_n && list_done) begin
      done_seen = 1'b1;
      got_cnt   = list_count;
      got_fail  = list_fail;
    end
  end

  task automatic model();
    bit stop;
    logic [31:0] a;
    int r, room, c;
    stop = 0;
    e_cnt = 0;
    e_fail = 0;
    for (int i = 0; i < n_seg && !stop; i++) begin
      if (s_len[i] == 0) begin
        stop = 1;
      end else begin
        a = s_addr[i];
        r = int'(s_len[i]);
        while (r > 0 && !stop) begin
          room = 32'h10000 - int'(a[15:0]);
          c = (r < room) ? r : room;
          if (e_cnt == MAX_ENT) begin
            e_fail = 1;
            stop = 1;
          end else begin
            e_addr[e_cnt] = a;
            e_len[e_cnt]  = 17'(c);
            e_cnt++;
            a = a + 32'(c);
            r = r - c;
          end
        end
        if (s_last[i]) stop = 1;
      end
    end
  endtask

  task automatic send_seg(input logic [31:0] a, input logic [LEN_W-1:0] l,
                          input logic lst);
    @(negedge clk);
    seg_valid = 1'b1;
    seg_addr  = a;
    seg_len   = l;
    seg_last  = lst;
    while (!seg_ready) @(negedge clk);
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  task automatic run_list(input string tag);
    int t;
    logic [31:0] ev;
    got_n = 0;
    done_seen = 0;
    model();
    for (int i = 0; i < n_seg; i++) send_seg(s_addr[i], s_len[i], s_last[i]);
    t = 0;
    while (!done_seen && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    check(done_seen, {tag, " R9 done seen"}, 32'(done_seen), 32'd1);
    check(got_fail == e_fail, {tag, " R6 fail flag"}, 32'(got_fail), 32'(e_fail));
    check(got_cnt == (e_fail ? 7'd0 : CNT_W'(e_cnt)), {tag, " R9 count"},
          32'(got_cnt), e_fail ? 32'd0 : 32'(e_cnt));
    if (!e_fail) begin
      check(got_n == 4 * e_cnt, {tag, " R9 word total"}, 32'(got_n), 32'(4 * e_cnt));
      for (int k = 0; k < e_cnt && 4 * k + 3 < got_n; k++) begin
        check(got_w[4*k] == 32'd0, {tag, " R3 word0"}, got_w[4*k], 32'd0);
        ev = swap(e_addr[k]);
        check(got_w[4*k+1] == ev, {tag, " R2/R4 addr word"}, got_w[4*k+1], ev);
        check(got_w[4*k+2] == 32'd0, {tag, " R3 word2"}, got_w[4*k+2], 32'd0);
        ev = swap({(k == e_cnt - 1), 14'd0, e_len[k]});
        check(got_w[4*k+3] == ev, {tag, " R1/R5 len word"}, got_w[4*k+3], ev);
      end
    end else begin
      for (int k = 3; k < got_n; k += 4)
        check(got_w[k][7] == 1'b0, {tag, " R6 no eol on failed list"},
              got_w[k], got_w[k] & 32'hffff_ff7f);
    end
  endtask

  // R11
  task automatic t_reset();
    rst_n = 1'b0;
    seg_valid = 1'b0;
    seg_addr = '0;
    seg_len = '0;
    seg_last = 1'b0;
    bp_en = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(desc_valid == 1'b0, "R11 desc_valid", 32'(desc_valid), 32'd0);
    check(list_done == 1'b0, "R11 list_done", 32'(list_done), 32'd0);
    check(seg_ready == 1'b1, "R11 seg_ready", 32'(seg_ready), 32'd1);
  endtask

  // R3 R4 R5: one small segment
  task automatic t_single();
    n_seg = 1;
    s_addr[0] = 32'h1000_0000; s_len[0] = 20'h200; s_last[0] = 1;
    run_list("single");
  endtask

  // R1 R2: segment crossing a 64 KiB boundary
  task automatic t_cross();
    n_seg = 1;
    s_addr[0] = 32'h0001_ff00; s_len[0] = 20'h300; s_last[0] = 1;
    run_list("cross");
  endtask

  // R1 R3 R10: full 64 KiB chunks under backpressure
  task automatic t_big_bp();
    bp_en = 1;
    n_seg = 1;
    s_addr[0] = 32'h0003_0000; s_len[0] = 20'h24000; s_last[0] = 1;
    run_list("big_bp");
    bp_en = 0;
  endtask

  // R8: zero-length segment terminates a multi-segment list
  task automatic t_zero_term();
    bp_en = 1;
    n_seg = 3;
    s_addr[0] = 32'h8000_fff0; s_len[0] = 20'h20;   s_last[0] = 0;
    s_addr[1] = 32'h4000_0004; s_len[1] = 20'h1fffc; s_last[1] = 0;
    s_addr[2] = 32'h0;         s_len[2] = 20'h0;     s_last[2] = 0;
    run_list("zero_term");
    bp_en = 0;
  endtask

  // R7: empty list
  task automatic t_empty();
    n_seg = 1;
    s_addr[0] = 32'h1234_0000; s_len[0] = 20'h0; s_last[0] = 0;
    run_list("empty");
    check(got_n == 0, "R7 no words", 32'(got_n), 32'd0);
  endtask

  // R6: exactly full table, then one more entry than fits
  task automatic t_capacity(input int nent, input string tag);
    n_seg = nent;
    for (int i = 0; i < nent; i++) begin
      s_addr[i] = 32'h0050_0000 + 32'(i) * 32'h100;
      s_len[i]  = 20'h10;
      s_last[i] = (i == nent - 1);
    end
    run_list(tag);
  endtask

  // R6: overflow inside a segment, followed by dropped segments
  task automatic t_drain();
    n_seg = 4;
    s_addr[0] = 32'h0;         s_len[0] = 20'hf0000; s_last[0] = 0;
    s_addr[1] = 32'h0100_0000; s_len[1] = 20'hf0000; s_last[1] = 0;
    s_addr[2] = 32'h0200_0000; s_len[2] = 20'hf0000; s_last[2] = 0;
    s_addr[3] = 32'h0300_0000; s_len[3] = 20'hf0000; s_last[3] = 0;
    n_seg = 6;
    s_addr[4] = 32'h0400_0000; s_len[4] = 20'hf0000; s_last[4] = 0;
    s_addr[5] = 32'h0;         s_len[5] = 20'h0;     s_last[5] = 0;
    run_list("drain");
    t_single();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    got_n = 0;
    done_seen = 0;
    t_reset();
    t_single();
    t_cross();
    t_big_bp();
    t_zero_term();
    t_empty();
    t_capacity(MAX_ENT, "cap64");
    t_capacity(MAX_ENT + 1, "cap65");
    t_drain();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule